// File: doc/BRIEF.md
# SDRAM Power-Up and Deep-Sleep Wake Sequencer

This block sits on the controller side of an SDRAM interface. It owns the clock-enable, chip-select, row strobe, column strobe, write-enable, bank and address pins while the memory is being brought up or woken, and it runs two fixed command sequences on them. The first is the cold start. A start pulse is followed by a pause that carries only no-operation commands. Then come one all-bank precharge, a configurable number of auto-refreshes and a mode register load. The second sequence leaves the deepest sleep state. A wake pulse repeats the same precharge, refresh and mode-load steps, without the pause.

Both sequences share one step engine. Each command takes one clock, and no-operation cycles of parameterised length follow it. A ready flag tells the rest of the controller when normal traffic may begin. While ready, a sleep request puts the memory into deep power-down. The block does this by issuing the burst-stop encoding with clock-enable low. From there it holds the memory deselected until a wake request arrives.

All pins are registered, so a request sampled on one clock edge first shows on the pins one cycle later. Wait lengths (pause, precharge, refresh, mode-load) are counts of clock cycles. The refresh count and the mode register value are also parameters.

Top module: `sdinit_seq`

## Requirements
- R1: During reset and until a start request is taken, cke is low, csN is high, ready is low, ba and addr are zero and {rasN,casN,weN} is 111.
- R2: After a start request in the idle state, the pins carry exactly PAUSE_CYC no-operation cycles (cke high, csN low, {rasN,casN,weN}=111). The next cycle carries an all-bank precharge: encoding 010, ba zero, addr bit AP_BIT high and every other addr bit low.
- R3: A precharge is followed by TRP_CYC no-operation cycles. Then come exactly REF_CNT auto-refresh commands (encoding 001 with cke high), and each is followed by TRFC_CYC no-operation cycles.
- R4: After the last refresh wait, one mode register set is issued (encoding 000, addr equal to MODE_VAL, ba zero). It is followed by TMRD_CYC no-operation cycles. On the next cycle ready goes high, and ready stays high with no-operation on the pins.
- R5: Every command other than no-operation lasts exactly one clock and is never directly followed by another command.
- R6: A sleep request taken while ready is high drops ready and issues one burst-stop cycle (encoding 110, csN low, cke low). After that the pins hold cke low and csN high until a wake.
- R7: A wake request taken in deep power-down raises cke and issues the precharge, refresh and mode-set steps of R2 to R4 without the pause. The precharge is on the first pin cycle of the sequence, and ready returns as in R4.
- R8: A wake request outside deep power-down, a sleep request while ready is low, and a start request outside the idle state each leave the pin sequence and ready unchanged.
- R9: When sleep and wake requests are taken in the same cycle, the sleep request wins while ready is high, and the wake request wins while in deep power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin the cold-start sequence (taken only when idle) |
| dpdReq | input | 1 | Enter deep power-down (taken only when ready) |
| wakeReq | input | 1 | Leave deep power-down (taken only in deep power-down) |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Memory accepts normal traffic |

## Verification
Sleep entry and wake can fall in the same cycle. Stray start, sleep and wake requests can also land on any step of a running sequence. The bench provokes the first case by raising sleep and wake together while ready, and again while asleep. It then checks that only the request valid in that state takes effect. For the second case it sweeps a combined start, sleep and wake pulse across every cycle of the cold-start sequence. Each cycle of the resulting pin stream is compared with a command stream computed from the wait parameters.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  // {rasN,casN,weN} with csN low
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    W_PAUSE,
    W_RP,
    W_RFC,
    W_MRD
  } waitSel_e;

  typedef struct packed {
    cmd_e     cmd;
    logic     ckeOn;
    logic     selOn;
    logic     loadWait;
    waitSel_e waitSel;
    logic     loadRef;
    logic     decRef;
    logic     rdy;
  } strobe_t;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    dpdReq,
  input  logic    wakeReq,
  input  logic    waitDone,
  input  logic    refLast,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_PAUSE, S_PRE, S_WRP, S_REF, S_WRFC,
    S_MRS, S_WMRD, S_READY, S_DPDE, S_DPD
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    stb.cmd      = CMD_NOP;
    stb.ckeOn    = 1'b1;
    stb.selOn    = 1'b1;
    stb.loadWait = 1'b0;
    stb.waitSel  = W_PAUSE;
    stb.loadRef  = 1'b0;
    stb.decRef   = 1'b0;
    stb.rdy      = 1'b0;
    unique case (state)
      S_IDLE: begin
        stb.ckeOn = 1'b0;
        stb.selOn = 1'b0;
        if (startReq) begin
          stb.loadWait = 1'b1;
          stb.waitSel  = W_PAUSE;
          stateNxt     = S_PAUSE;
        end
      end
      S_PAUSE: if (waitDone) stateNxt = S_PRE;
      S_PRE: begin
        stb.cmd      = CMD_PRE;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_RP;
        stb.loadRef  = 1'b1;
        stateNxt     = S_WRP;
      end
      S_WRP: if (waitDone) stateNxt = S_REF;
      S_REF: begin
        stb.cmd      = CMD_REF;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_RFC;
        stateNxt     = S_WRFC;
      end
      S_WRFC: begin
        if (waitDone) begin
          if (refLast) begin
            stateNxt = S_MRS;
          end else begin
            stb.decRef = 1'b1;
            stateNxt   = S_REF;
          end
        end
      end
      S_MRS: begin
        stb.cmd      = CMD_MRS;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_MRD;
        stateNxt     = S_WMRD;
      end
      S_WMRD: if (waitDone) stateNxt = S_READY;
      S_READY: begin
        stb.rdy = 1'b1;
        if (dpdReq) stateNxt = S_DPDE;
      end
      S_DPDE: begin
        stb.cmd   = CMD_BST;
        stb.ckeOn = 1'b0;
        stateNxt  = S_DPD;
      end
      S_DPD: begin
        stb.ckeOn = 1'b0;
        stb.selOn = 1'b0;
        if (wakeReq) stateNxt = S_PRE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/sdinit_dp.sv
module sdinit_dp
  import sdinit_pkg::*;
#(
  parameter int PAUSE_CYC = 5,
  parameter int TRP_CYC   = 2,
  parameter int TRFC_CYC  = 3,
  parameter int TMRD_CYC  = 2,
  parameter int REF_CNT   = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 13'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic              waitDone,
  output logic              refLast,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int MAX_A  = (PAUSE_CYC > TRP_CYC) ? PAUSE_CYC : TRP_CYC;
  localparam int MAX_B  = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WAIT_W = (MAX_W < 2) ? 1 : $clog2(MAX_W);
  localparam int REF_W  = (REF_CNT < 2) ? 1 : $clog2(REF_CNT);

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic [WAIT_W-1:0] loadVal;

  always_comb begin
    unique case (stb.waitSel)
      W_PAUSE: loadVal = WAIT_W'(PAUSE_CYC - 1);
      W_RP:    loadVal = WAIT_W'(TRP_CYC - 1);
      W_RFC:   loadVal = WAIT_W'(TRFC_CYC - 1);
      default: loadVal = WAIT_W'(TMRD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.loadWait) begin
      waitCnt <= loadVal;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (stb.loadRef) begin
      refCnt <= REF_W'(REF_CNT - 1);
    end else if (stb.decRef) begin
      refCnt <= refCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);
  assign refLast  = (refCnt == '0);

  logic [ADDR_W-1:0] addrNxt;
  always_comb begin
    unique case (stb.cmd)
      CMD_PRE: addrNxt = ADDR_W'(1) << AP_BIT;
      CMD_MRS: addrNxt = MODE_VAL;
      default: addrNxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke   <= 1'b0;
      csN   <= 1'b1;
      rasN  <= 1'b1;
      casN  <= 1'b1;
      weN   <= 1'b1;
      ba    <= '0;
      addr  <= '0;
      ready <= 1'b0;
    end else begin
      cke   <= stb.ckeOn;
      csN   <= ~stb.selOn;
      rasN  <= stb.cmd[2];
      casN  <= stb.cmd[1];
      weN   <= stb.cmd[0];
      ba    <= '0;
      addr  <= addrNxt;
      ready <= stb.rdy;
    end
  end

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int PAUSE_CYC = 5,
  parameter int TRP_CYC   = 2,
  parameter int TRFC_CYC  = 3,
  parameter int TMRD_CYC  = 2,
  parameter int REF_CNT   = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 13'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              dpdReq,
  input  logic              wakeReq,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  strobe_t stb;
  logic    waitDone;
  logic    refLast;

  sdinit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .dpdReq   (dpdReq),
    .wakeReq  (wakeReq),
    .waitDone (waitDone),
    .refLast  (refLast),
    .stb      (stb)
  );

  sdinit_dp #(
    .PAUSE_CYC (PAUSE_CYC),
    .TRP_CYC   (TRP_CYC),
    .TRFC_CYC  (TRFC_CYC),
    .TMRD_CYC  (TMRD_CYC),
    .REF_CNT   (REF_CNT),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .AP_BIT    (AP_BIT),
    .MODE_VAL  (MODE_VAL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .waitDone (waitDone),
    .refLast  (refLast),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .addr     (addr),
    .ready    (ready)
  );

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk #(
  parameter int REF_CNT = 2,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int AP_BIT  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);

  logic [2:0] code;
  logic       isCmd, isPre, isRef, isMrs, isBst;
  assign code  = {rasN, casN, weN};
  assign isCmd = !csN && (code != 3'b111);
  assign isPre = !csN && (code == 3'b010);
  assign isRef = !csN && (code == 3'b001);
  assign isMrs = !csN && (code == 3'b000);
  assign isBst = !csN && (code == 3'b110);

  logic [7:0] refSincePre;
  logic       mrsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSincePre <= '0;
      mrsSeen     <= 1'b0;
    end else if (isPre) begin
      refSincePre <= '0;
      mrsSeen     <= 1'b0;
    end else begin
      if (isRef && refSincePre != 8'hff) refSincePre <= refSincePre + 1'b1;
      if (isMrs) mrsSeen <= 1'b1;
    end
  end

  p_one_clock_r5: assert property (@(posedge clk) disable iff (!rstN)
    isCmd |=> !isCmd);

  p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (addr[AP_BIT] && ba == '0));

  p_ref_cke_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> cke);

  p_refs_before_mrs_r3: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (refSincePre >= 8'(REF_CNT)));

  p_ready_after_mrs_r4: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> mrsSeen);

  p_ready_rise_nop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(!isCmd && cke));

  p_bst_cke_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    isBst |-> (!cke && !ready));

  p_bst_then_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    isBst |=> (csN && !cke));

endmodule

bind sdinit_seq sdinit_seq_chk #(
  .REF_CNT (REF_CNT),
  .ADDR_W  (ADDR_W),
  .BA_W    (BA_W),
  .AP_BIT  (AP_BIT)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .cke   (cke),
  .csN   (csN),
  .rasN  (rasN),
  .casN  (casN),
  .weN   (weN),
  .ba    (ba),
  .addr  (addr),
  .ready (ready)
);

// File: tb/sdinit_seq_tb.sv
`timescale 1ns/1ps
module sdinit_seq_tb;

  localparam int PAUSE  = 5;
  localparam int TRP    = 2;
  localparam int TRFC   = 3;
  localparam int TMRD   = 2;
  localparam int NREF   = 2;
  localparam int AW     = 13;
  localparam int BW     = 2;
  localparam int AP     = 10;
  localparam logic [AW-1:0] MODE = 13'h032;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, dpdReq = 1'b0, wakeReq = 1'b0;
  logic cke, csN, rasN, casN, weN, ready;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sdinit_seq #(
    .PAUSE_CYC(PAUSE), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
    .REF_CNT(NREF), .ADDR_W(AW), .BA_W(BW), .AP_BIT(AP), .MODE_VAL(MODE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dpdReq(dpdReq),
    .wakeReq(wakeReq), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .ready(ready)
  );

  // packed pin view: {cke, csN, code[2:0], ba, addr, ready}
  localparam int PW = 6 + BW + AW;

  function automatic logic [PW-1:0] pinsOf(logic k, logic c, logic [2:0] cd,
                                           logic [AW-1:0] a, logic r);
    return {k, c, cd, {BW{1'b0}}, a, r};
  endfunction

  task automatic chk(string req, logic [PW-1:0] expv);
    logic [PW-1:0] act;
    act = {cke, csN, rasN, casN, weN, ba, addr, ready};
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, expv);
    end
  endtask

  function automatic int seqLen(int p);
    return p + 1 + TRP + NREF * (1 + TRFC) + 1 + TMRD;
  endfunction

  function automatic logic [2:0] expCmd(int i, int p);
    int j;
    j = i - p;
    if (j < 0) return 3'b111;
    if (j == 0) return 3'b010;
    j -= 1 + TRP;
    if (j < 0) return 3'b111;
    for (int r = 0; r < NREF; r++) begin
      if (j == 0) return 3'b001;
      j -= 1 + TRFC;
      if (j < 0) return 3'b111;
    end
    if (j == 0) return 3'b000;
    return 3'b111;
  endfunction

  function automatic string reqOf(int i, int p);
    if (i <= p) return "R2";
    if (i < p + 1 + TRP + NREF * (1 + TRFC)) return "R3";
    return "R4";
  endfunction

  function automatic logic [PW-1:0] expPins(int i, int p);
    logic [2:0] c;
    logic [AW-1:0] a;
    c = expCmd(i, p);
    a = (c == 3'b010) ? (AW'(1) << AP) : (c == 3'b000) ? MODE : '0;
    return pinsOf(1'b1, 1'b0, c, a, (i >= seqLen(p)));
  endfunction

  // Sampled at a negedge where index 0 of the sequence is on the pins.
  // disturbAt >= 0 pulses start, sleep and wake together after that index (R8).
  task automatic runSeq(int p, int disturbAt, string tag);
    for (int i = 0; i <= seqLen(p); i++) begin
      chk((tag != "") ? tag : reqOf(i, p), expPins(i, p));
      startReq = (i == disturbAt);
      dpdReq   = (i == disturbAt);
      wakeReq  = (i == disturbAt);
      @(negedge clk);
    end
    startReq = 1'b0; dpdReq = 1'b0; wakeReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    startReq = 1'b0; dpdReq = 1'b0; wakeReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
  endtask

  task automatic coldStart(int disturbAt);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R2", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
    @(negedge clk);
    runSeq(PAUSE, disturbAt, (disturbAt >= 0) ? "R8" : "");
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R8: sleep and wake before start leave the idle pins alone
    wakeReq = 1'b1; dpdReq = 1'b1;
    repeat (2) @(negedge clk);
    wakeReq = 1'b0; dpdReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
      @(negedge clk);
    end

    // R2 R3 R4 R5: clean cold start, then stray requests swept over each cycle
    coldStart(-1);
    for (int k = 0; k <= seqLen(PAUSE) - 2; k++) begin
      doReset();
      coldStart(k);
    end

    // R8: wake while ready is ignored
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8", pinsOf(1'b1, 1'b0, 3'b111, '0, 1'b1));
      @(negedge clk);
    end

    // R6 R7 R9: sleep and wake round trips with varied sleep lengths
    for (int hold = 1; hold <= 4; hold++) begin
      for (int both = 0; both < 2; both++) begin
        dpdReq = 1'b1; wakeReq = both[0];
        @(negedge clk);
        dpdReq = 1'b0; wakeReq = 1'b0;
        chk("R6", pinsOf(1'b1, 1'b0, 3'b111, '0, 1'b1));
        @(negedge clk);
        chk(both ? "R9" : "R6", pinsOf(1'b0, 1'b0, 3'b110, '0, 1'b0));
        @(negedge clk);
        for (int h = 0; h < hold; h++) begin
          chk("R6", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
          dpdReq = (h == 0);
          @(negedge clk);
        end
        wakeReq = 1'b1; dpdReq = both[0];
        @(negedge clk);
        wakeReq = 1'b0; dpdReq = 1'b0;
        chk(both ? "R9" : "R7", pinsOf(1'b0, 1'b1, 3'b111, '0, 1'b0));
        @(negedge clk);
        runSeq(0, -1, both ? "R9" : "R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule